// File: doc/BRIEF.md
# Multi-Lane Serial Audio Transmitter

This block is a transmit-only serial audio port for eight-channel surround playback. It drives four serial data lanes in parallel. All four lanes share one bit clock and one frame sync, and the block generates both itself as bus master. Each lane carries a left and a right word per frame in left-justified framing. Each lane has a private 32-entry sample queue of 32-bit words, and software or a DMA engine loads it through that lane's write strobe.

A lane-enable mask selects which lanes take part. An enabled lane takes one queue entry at the start of every word it sends. A disabled lane sends zeros and leaves its queue untouched. A single warning output is meant to drive an interrupt or a DMA request. It reports that at least one enabled queue has run dry, and it is refreshed once per frame while the port runs. A lane that finds its queue empty when a word is due sends a zero word and latches a sticky underrun flag. The other lanes carry on unaffected.

The bit clock comes from the master clock through a programmable divider. The left word and the right word each have their own width. The left word travels while frame sync is high and the right word while it is low.

Top module: `surround_tx`

## Requirements
- R1: A write strobe on a lane whose queue holds fewer than 32 entries appends its 32-bit word, and the lane transmits its entries in the order they were written.
- R2: A write strobe on a lane whose queue already holds 32 entries is discarded: that word is never transmitted and the queue occupancy stays at 32.
- R3: While the port runs, the bit clock toggles every div_half+1 master-clock cycles, so its period is 2*(div_half+1) cycles. Frame sync and the serial data change only in the cycle in which the bit clock falls.
- R4: Words leave MSB first. Frame sync is 1 for every bit of the left word and 0 for every bit of the right word. The first left word after enabling is presented before the first rising bit-clock edge, and the receiver samples every bit on a rising edge.
- R5: The left word is first_len bits long and the right word rest_len bits long, each clamped to the range 8 to 32. A word of width w carries bits 31 down to 32-w of its queue entry. Both widths are captured at each frame start.
- R6: All lanes share the same frame and bit timing, and each enabled lane removes exactly one queue entry per word.
- R7: A lane whose bit in lane_mask is 0 outputs 0, never removes a queue entry and never sets its underrun flag.
- R8: An enabled lane whose queue is empty when a word is due outputs 0 for the whole word and sets underrun_o for that lane. The other lanes' data is unaffected.
- R9: An underrun flag stays 1 until a pulse on its underrun_clr bit clears it. A new underrun in the same cycle wins over the clear.
- R10: While the port is idle, warn_o follows, one cycle late, whether any enabled queue is empty. While the port runs, warn_o changes only at a frame start, using the queue states before that frame's left word is taken.
- R11: After reset all outputs are 0 and every queue is empty.
- R12: Dropping tx_en returns the bit clock, frame sync and data to 0 in the next cycle and keeps the queue contents. Raising it again starts a fresh frame with a left word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Port enable; the port runs while it is 1 |
| div_half | input | 8 | Bit-clock half period minus one, in master-clock cycles |
| first_len | input | 6 | Left word width in bits (8 to 32) |
| rest_len | input | 6 | Right word width in bits (8 to 32) |
| lane_mask | input | 4 | Per-lane enable, bit i for lane i |
| wr_en | input | 4 | Per-lane write strobe |
| wr_data | input | 128 | Write words, lane i at bits 32*i+31 down to 32*i |
| underrun_clr | input | 4 | Per-lane underrun flag clear pulse |
| bclk_o | output | 1 | Bit clock |
| fs_o | output | 1 | Frame sync, 1 during the left word |
| sdata_o | output | 4 | Serial data, one bit per lane |
| warn_o | output | 1 | Some enabled queue is empty |
| underrun_o | output | 4 | Sticky per-lane underrun flags |

## Verification
The properties watch several rules on every cycle. Queue occupancy never exceeds 32 and holds at 32 under a discarded write. Frame sync and data move only on a falling bit clock. The outputs are quiet after tx_en drops. Masked lanes never read their queue or flag an underrun. The underrun flags are sticky. While running, the warning changes only together with a frame-sync edge. Only the bench's scenarios can show the bit-level content of each word, the order of the data, the width clamping, the exact bit-clock period, the zero fill under underrun and how the warning responds when the queues drain.

// File: rtl/stx_pkg.sv
package stx_pkg;

    localparam int SLOT_W   = 32;
    localparam int WLEN_W   = 6;
    localparam int MIN_WLEN = 8;

    typedef enum logic {
        SLOT_LEFT  = 1'b0,
        SLOT_RIGHT = 1'b1
    } slot_e;

    typedef struct packed {
        logic [WLEN_W-1:0] first_len;
        logic [WLEN_W-1:0] rest_len;
    } wlen_t;

    // Broadcast from the sequencer to every lane
    typedef struct packed {
        logic  start;
        logic  shift;
        slot_e slot;
    } seq_t;

    function automatic logic [WLEN_W-1:0] clamp_len(input logic [WLEN_W-1:0] w);
        if (w < WLEN_W'(MIN_WLEN)) return WLEN_W'(MIN_WLEN);
        if (w > WLEN_W'(SLOT_W))   return WLEN_W'(SLOT_W);
        return w;
    endfunction

endpackage

// File: rtl/stx_clkgen.sv
module stx_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_half,
    output logic             bclk,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            bclk <= 1'b0;
        end else if (cnt == div_half) begin
            cnt  <= '0;
            bclk <= ~bclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

    // Cycle whose closing edge drops the bit clock
    assign fall_tick = run && bclk && (cnt == div_half);
endmodule

// File: rtl/stx_sequencer.sv
module stx_sequencer import stx_pkg::*; #(
    parameter int LANES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              fall_tick,
    input  logic [WLEN_W-1:0] first_len,
    input  logic [WLEN_W-1:0] rest_len,
    input  logic [LANES-1:0]  lane_mask,
    input  logic [LANES-1:0]  lane_empty,
    output logic              running,
    output seq_t              seq,
    output logic              fs_o,
    output logic              warn_o
);
    slot_e             slot_q;
    logic [WLEN_W-1:0] bit_cnt;
    wlen_t             len_q;
    logic [WLEN_W-1:0] cur_len;
    logic              last_bit;
    logic              run;
    logic              frame_start;

    assign run      = running && tx_en;
    assign cur_len  = (slot_q == SLOT_RIGHT) ? len_q.rest_len : len_q.first_len;
    assign last_bit = (bit_cnt == cur_len - 1'b1);

    always_comb begin
        seq.start = (tx_en && !running) || (run && fall_tick && last_bit);
        seq.shift = run && fall_tick && !last_bit;
        seq.slot  = running ? slot_e'(~slot_q) : SLOT_LEFT;
    end

    assign frame_start = seq.start && (seq.slot == SLOT_LEFT);

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
        end else begin
            running <= tx_en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !tx_en) begin
            slot_q  <= SLOT_LEFT;
            bit_cnt <= '0;
            fs_o    <= 1'b0;
            if (rst) begin
                len_q <= '{first_len: WLEN_W'(MIN_WLEN), rest_len: WLEN_W'(MIN_WLEN)};
            end
        end else if (seq.start) begin
            slot_q  <= seq.slot;
            bit_cnt <= '0;
            fs_o    <= (seq.slot == SLOT_LEFT);
            if (frame_start) begin
                len_q.first_len <= clamp_len(first_len);
                len_q.rest_len  <= clamp_len(rest_len);
            end
        end else if (seq.shift) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Idle: follow every cycle; running: refresh at frame start, pre-pop
    always_ff @(posedge clk) begin
        if (rst) begin
            warn_o <= 1'b0;
        end else if (!run || frame_start) begin
            warn_o <= |(lane_mask & lane_empty);
        end
    end
endmodule

// File: rtl/stx_lane_fifo.sv
module stx_lane_fifo #(
    parameter int DEPTH = 32,
    parameter int DW    = 32,
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    input  logic             pop,
    output logic [DW-1:0]    rd_data,
    output logic             empty,
    output logic [LVL_W-1:0] level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (level == '0);
    assign do_push = wr_en && (level != LVL_W'(DEPTH));
    assign do_pop  = pop && !empty;
    assign rd_data = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/stx_lane_ser.sv
module stx_lane_ser import stx_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  seq_t              seq,
    input  logic              lane_on,
    input  logic              empty,
    input  logic [SLOT_W-1:0] rd_data,
    input  logic              ur_clr,
    output logic              pop,
    output logic              sdata,
    output logic              underrun
);
    logic [SLOT_W-1:0] sh;
    logic [SLOT_W-1:0] word;
    logic              due, starve;

    assign due    = seq.start && lane_on;
    assign pop    = due && !empty;
    assign starve = due && empty;
    assign word   = pop ? rd_data : '0;

    always_ff @(posedge clk) begin
        if (rst || !tx_en) begin
            sdata <= 1'b0;
            sh    <= '0;
        end else if (seq.start) begin
            sdata <= word[SLOT_W-1];
            sh    <= {word[SLOT_W-2:0], 1'b0};
        end else if (seq.shift) begin
            sdata <= sh[SLOT_W-1];
            sh    <= {sh[SLOT_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            underrun <= 1'b0;
        end else if (starve) begin
            underrun <= 1'b1;
        end else if (ur_clr) begin
            underrun <= 1'b0;
        end
    end
endmodule

// File: rtl/surround_tx.sv
module surround_tx import stx_pkg::*; #(
    parameter int LANES = 4,
    parameter int DEPTH = 32,
    parameter int DIV_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tx_en,
    input  logic [DIV_W-1:0]        div_half,
    input  logic [WLEN_W-1:0]       first_len,
    input  logic [WLEN_W-1:0]       rest_len,
    input  logic [LANES-1:0]        lane_mask,
    input  logic [LANES-1:0]        wr_en,
    input  logic [LANES*SLOT_W-1:0] wr_data,
    input  logic [LANES-1:0]        underrun_clr,
    output logic                    bclk_o,
    output logic                    fs_o,
    output logic [LANES-1:0]        sdata_o,
    output logic                    warn_o,
    output logic [LANES-1:0]        underrun_o
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic                   running;
    logic                   fall_tick;
    seq_t                   seq;
    logic [LANES-1:0]       lane_empty;
    logic [LANES-1:0]       lane_pop;
    logic [LANES*LVL_W-1:0] level_all;
    logic [SLOT_W-1:0]      rd_data [LANES];

    stx_clkgen #(.DIV_W(DIV_W)) clkgen_i (
        .clk       (clk),
        .rst       (rst),
        .run       (running && tx_en),
        .div_half  (div_half),
        .bclk      (bclk_o),
        .fall_tick (fall_tick)
    );

    stx_sequencer #(.LANES(LANES)) seq_i (
        .clk        (clk),
        .rst        (rst),
        .tx_en      (tx_en),
        .fall_tick  (fall_tick),
        .first_len  (first_len),
        .rest_len   (rest_len),
        .lane_mask  (lane_mask),
        .lane_empty (lane_empty),
        .running    (running),
        .seq        (seq),
        .fs_o       (fs_o),
        .warn_o     (warn_o)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        stx_lane_fifo #(.DEPTH(DEPTH), .DW(SLOT_W), .LVL_W(LVL_W)) fifo_i (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en[g]),
            .wr_data (wr_data[g*SLOT_W +: SLOT_W]),
            .pop     (lane_pop[g]),
            .rd_data (rd_data[g]),
            .empty   (lane_empty[g]),
            .level   (level_all[g*LVL_W +: LVL_W])
        );

        stx_lane_ser ser_i (
            .clk      (clk),
            .rst      (rst),
            .tx_en    (tx_en),
            .seq      (seq),
            .lane_on  (lane_mask[g]),
            .empty    (lane_empty[g]),
            .rd_data  (rd_data[g]),
            .ur_clr   (underrun_clr[g]),
            .pop      (lane_pop[g]),
            .sdata    (sdata_o[g]),
            .underrun (underrun_o[g])
        );
    end
endmodule

// File: rtl/stx_checker.sv
module stx_checker #(
    parameter int LANES = 4,
    parameter int DEPTH = 32,
    parameter int LVL_W = 6
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   tx_en,
    input logic                   bclk_o,
    input logic                   fs_o,
    input logic [LANES-1:0]       sdata_o,
    input logic                   warn_o,
    input logic [LANES-1:0]       lane_mask,
    input logic [LANES-1:0]       wr_en,
    input logic [LANES-1:0]       underrun_o,
    input logic [LANES-1:0]       underrun_clr,
    input logic [LANES-1:0]       lane_pop,
    input logic [LANES*LVL_W-1:0] level_all
);
    p_fs_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_en && $past(tx_en) && $past(tx_en, 2) && !$stable(fs_o)) |-> $fell(bclk_o));

    p_data_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_en && $past(tx_en) && $past(tx_en, 2) && !$stable(sdata_o)) |-> $fell(bclk_o));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        $past(!tx_en) |-> (!bclk_o && !fs_o && sdata_o == '0));

    p_warn_at_frame_r10: assert property (@(posedge clk) disable iff (rst)
        (tx_en && $past(tx_en) && $past(tx_en, 2) && !$stable(warn_o)) |-> $rose(fs_o));

    for (genvar i = 0; i < LANES; i++) begin : g_chk
        p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
            level_all[i*LVL_W +: LVL_W] <= LVL_W'(DEPTH));

        p_full_write_ignored_r2: assert property (@(posedge clk) disable iff (rst)
            (level_all[i*LVL_W +: LVL_W] == LVL_W'(DEPTH) && wr_en[i] && !lane_pop[i])
            |=> (level_all[i*LVL_W +: LVL_W] == LVL_W'(DEPTH)));

        p_off_lane_no_pop_r7: assert property (@(posedge clk) disable iff (rst)
            !lane_mask[i] |-> !lane_pop[i]);

        p_off_lane_no_err_r7: assert property (@(posedge clk) disable iff (rst)
            (!lane_mask[i] && !underrun_o[i]) |=> !underrun_o[i]);

        p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
            (underrun_o[i] && !underrun_clr[i]) |=> underrun_o[i]);
    end
endmodule

bind surround_tx stx_checker #(.LANES(LANES), .DEPTH(DEPTH), .LVL_W(LVL_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .tx_en        (tx_en),
    .bclk_o       (bclk_o),
    .fs_o         (fs_o),
    .sdata_o      (sdata_o),
    .warn_o       (warn_o),
    .lane_mask    (lane_mask),
    .wr_en        (wr_en),
    .underrun_o   (underrun_o),
    .underrun_clr (underrun_clr),
    .lane_pop     (lane_pop),
    .level_all    (level_all)
);

// File: tb/surround_tx_tb_top.sv
module surround_tx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 4;
    localparam int DEPTH      = 32;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               tx_en = 1'b0;
    logic [7:0]         div_half = 8'd1;
    logic [5:0]         first_len = 6'd24;
    logic [5:0]         rest_len = 6'd24;
    logic [LANES-1:0]   lane_mask = '0;
    logic [LANES-1:0]   wr_en = '0;
    logic [LANES*32-1:0] wr_data = '0;
    logic [LANES-1:0]   underrun_clr = '0;
    logic               bclk_o, fs_o, warn_o;
    logic [LANES-1:0]   sdata_o, underrun_o;

    surround_tx dut_i (
        .clk(clk), .rst(rst), .tx_en(tx_en), .div_half(div_half),
        .first_len(first_len), .rest_len(rest_len), .lane_mask(lane_mask),
        .wr_en(wr_en), .wr_data(wr_data), .underrun_clr(underrun_clr),
        .bclk_o(bclk_o), .fs_o(fs_o), .sdata_o(sdata_o), .warn_o(warn_o),
        .underrun_o(underrun_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 0;
    logic [31:0] model [LANES][$];
    logic [LANES-1:0] exp_ur = '0;
    int slot_pos;
    int fl, rl;
    logic prev_bclk;
    int last_rise, rise_gap;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int bclamp(input int w);
        if (w < 8) return 8;
        if (w > 32) return 32;
        return w;
    endfunction

    task automatic check(input string req, input logic [63:0] act,
                         input logic [63:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input int lane, input logic [31:0] d);
        @(negedge clk);
        wr_en[lane] = 1'b1;
        wr_data[lane*32 +: 32] = d;
        if (model[lane].size() < DEPTH) model[lane].push_back(d);
        @(negedge clk);
        wr_en = '0;
    endtask

    task automatic fill_random(input int lane, input int n);
        for (int k = 0; k < n; k++) push(lane, $urandom());
    endtask

    task automatic set_widths(input int a, input int b);
        first_len = 6'(a);
        rest_len  = 6'(b);
        fl = bclamp(a);
        rl = bclamp(b);
    endtask

    task automatic start_tx();
        @(negedge clk);
        tx_en = 1'b1;
        slot_pos = 0;
        prev_bclk = 1'b0;
        last_rise = cyc;
    endtask

    // Called at a negedge right after a decode: no extra wait before dropping
    task automatic stop_tx();
        tx_en = 1'b0;
        @(negedge clk);
        check("R12", {bclk_o, fs_o, sdata_o}, '0, "outputs quiet after disable");
    endtask

    task automatic next_rise();
        bit got = 0;
        while (!got) begin
            @(negedge clk);
            if (bclk_o === 1'b1 && prev_bclk === 1'b0) begin
                got = 1;
                rise_gap = cyc - last_rise;
                last_rise = cyc;
            end
            prev_bclk = bclk_o;
        end
    endtask

    task automatic decode_words(input int n, input string req);
        int bad_gap = 0;
        bit first = 1;
        for (int k = 0; k < n; k++) begin
            int w = (slot_pos == 0) ? fl : rl;
            logic [31:0] e [LANES];
            logic [31:0] got [LANES];
            bit fs_ok = 1;
            for (int l = 0; l < LANES; l++) begin
                got[l] = '0;
                if (lane_mask[l] && model[l].size() > 0) e[l] = model[l].pop_front();
                else begin
                    e[l] = '0;
                    if (lane_mask[l]) exp_ur[l] = 1'b1;
                end
            end
            for (int b = 0; b < w; b++) begin
                next_rise();
                if (!first && rise_gap != 2 * (int'(div_half) + 1)) bad_gap++;
                first = 0;
                for (int l = 0; l < LANES; l++) got[l] = {got[l][30:0], sdata_o[l]};
                if (fs_o !== (slot_pos == 0)) fs_ok = 0;
            end
            for (int l = 0; l < LANES; l++)
                check(req, got[l], e[l] >> (32 - w), $sformatf("lane %0d word %0d", l, k));
            check("R4", fs_ok, 1, "frame sync level over word");
            slot_pos ^= 1;
        end
        check("R3", bad_gap, 0, "bit clock period mismatches");
    endtask

    task automatic clear_ur(input logic [LANES-1:0] m);
        @(negedge clk);
        underrun_clr = m;
        @(negedge clk);
        underrun_clr = '0;
        exp_ur &= ~m;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11", {bclk_o, fs_o, sdata_o, warn_o, underrun_o}, '0, "reset outputs");

        // R10 idle warning with empty enabled queues
        lane_mask = 4'hF;
        @(negedge clk); @(negedge clk);
        check("R10", warn_o, 1, "idle warn with empty queues");

        // Main random run: 24-bit words, 3 frames then underrun
        set_widths(24, 24);
        div_half = 8'd1;
        for (int l = 0; l < LANES; l++) fill_random(l, 6);
        @(negedge clk);
        check("R10", warn_o, 0, "idle warn with all queues loaded");
        start_tx();
        decode_words(6, "R1");
        check("R10", warn_o, 0, "warn held before next frame");
        decode_words(2, "R8");
        check("R10", warn_o, 1, "warn at frame start with empty queues");
        check("R8", underrun_o, 4'hF, "underrun flags");
        stop_tx();
        clear_ur(4'hF);
        check("R9", underrun_o, 4'h0, "underrun cleared");

        // Unequal widths, slower bit clock
        set_widths(16, 8);
        div_half = 8'd2;
        for (int l = 0; l < LANES; l++) fill_random(l, 4);
        start_tx();
        decode_words(4, "R5");
        stop_tx();
        check("R6", underrun_o, exp_ur, "no underrun with exact fill");

        // Masked lanes: 0 and 2 enabled; lane 1 preloaded, lane 3 empty
        lane_mask = 4'b0101;
        fill_random(0, 4);
        fill_random(2, 4);
        push(1, 32'hA5C3_0F96);
        push(1, 32'h1234_5678);
        @(negedge clk);
        check("R10", warn_o, 0, "disabled empty lane ignored by warn");
        set_widths(20, 20);
        start_tx();
        decode_words(4, "R7");
        stop_tx();
        check("R7", underrun_o, 4'h0, "no underrun on disabled lanes");
        lane_mask = 4'b0010;
        start_tx();
        decode_words(2, "R7");
        stop_tx();
        check("R12", underrun_o, 4'h0, "fresh frame after re-enable");

        // Full queue: 33rd write discarded, fastest bit clock
        lane_mask = 4'b0001;
        set_widths(32, 32);
        div_half = 8'd0;
        for (int k = 0; k < 33; k++) push(0, 32'hC0DE_0000 + 32'(k));
        start_tx();
        decode_words(34, "R2");
        check("R8", underrun_o, 4'b0001, "underrun after discarded write");
        stop_tx();
        clear_ur(4'hF);

        // Clamped widths and per-lane underrun independence
        lane_mask = 4'hF;
        set_widths(4, 40);
        div_half = 8'd1;
        fill_random(0, 2);
        for (int l = 1; l < LANES; l++) fill_random(l, 4);
        start_tx();
        decode_words(4, "R5");
        check("R8", underrun_o, 4'b0001, "only starved lane flagged");
        check("R10", warn_o, 1, "warn with one starved lane");
        stop_tx();
        clear_ur(4'hF);

        // Constrained random widths and dividers
        for (int it = 0; it < 4; it++) begin
            set_widths(8 + $urandom_range(24), 8 + $urandom_range(24));
            div_half = 8'($urandom_range(3));
            for (int l = 0; l < LANES; l++) fill_random(l, 4);
            start_tx();
            decode_words(4, "R6");
            stop_tx();
            check("R6", underrun_o, 4'h0, "random run underrun");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule